// File: doc/BRIEF.md
# Message-Object Control Register Bank

This block keeps the control flags for the fifteen message objects of a CAN controller. Each object has four flags: the object is valid, transmit interrupt enable, receive interrupt enable, and interrupt pending. Each flag is stored once. Software sees each flag as a two-bit field. The upper bit holds the flag and the lower bit holds its inverse. A single write can therefore set some flags, clear others and leave the rest untouched, with no read-modify-write.

The bit engine reports three kinds of event:
- a per-object strobe for a successful transmit;
- a per-object strobe for a successful receive;
- a strobe for any valid received frame.

The bank combines these with each object's direction, its enable flags and two global enables. It then produces registered one-cycle interrupt request pulses and sets the pending flag of the object concerned. The valid flags go to the bit engine as a vector.

The register bus is plain control, with no back-pressure. A write is always taken on the clock edge where it is presented. A read returns data on the cycle after its request.

Top module: `mocr_bank`

## Requirements
- R1: The address selects the object by its number, 1 to 15. Within each 8-bit word, bits 7:6 hold valid, 5:4 hold transmit enable, 3:2 hold receive enable and 1:0 hold pending. Writes to address 0 are dropped, and reads of address 0 return 0.
- R2: Writing 2'b10 to a field sets its flag. Writing 2'b01 clears it.
- R3: Writing 2'b11 or 2'b00 to a field leaves its flag unchanged. A write never alters the flags of another field or another object.
- R4: A read returns each field as {flag, ~flag}, in `rd_data` on the cycle after `rd_en`.
- R5: A transmit-direction object that sees `tx_ok` while its transmit enable and `glb_ie` are both 1 pulses its `tx_irq_vec` bit one cycle later and sets its pending flag.
- R6: A receive-direction object that sees `rx_ok` while its receive enable and `glb_ie` are both 1 pulses its `rx_irq_vec` bit one cycle later and sets its pending flag.
- R7: Transmit-direction objects ignore `rx_ok` and their receive enable. Receive-direction objects ignore `tx_ok` and their transmit enable. An ignored event gives no pulse and leaves pending unchanged.
- R8: While `glb_ie` is 0, no transmit or receive pulse occurs and no pending flag is set.
- R9: `frame_ok` while `stat_ie` is 1 pulses `stat_irq` one cycle later, whether or not any object takes the frame. While `stat_ie` is 0, `frame_ok` gives no pulse.
- R10: A reception into an object with its receive enable set, coinciding with `frame_ok` while `stat_ie` is 1, gives both a `rx_irq_vec` pulse and a `stat_irq` pulse in the same cycle.
- R11: If a qualifying event and a software clear of the same pending flag fall in the same cycle, the flag ends set.
- R12: Reset leaves every control flag unchanged. It clears `rd_data`, `tx_irq_vec`, `rx_irq_vec` and `stat_irq`.
- R13: Bit i of `obj_valid` equals the valid flag of object i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the outputs only |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 4 | Object number for the write |
| wr_data | input | 8 | Four true/complement fields |
| rd_en | input | 1 | Read request |
| rd_addr | input | 4 | Object number for the read |
| rd_data | output | 8 | Read data, registered |
| tx_ok | input | 15 | Per-object successful transmit strobe, bit i is object i |
| rx_ok | input | 15 | Per-object successful receive strobe |
| obj_is_tx | input | 15 | 1 = object transmits, 0 = object receives |
| frame_ok | input | 1 | A valid frame was received |
| glb_ie | input | 1 | Global interrupt enable |
| stat_ie | input | 1 | Status interrupt enable |
| obj_valid | output | 15 | Valid flag of each object |
| tx_irq_vec | output | 15 | Transmit interrupt pulses per object |
| rx_irq_vec | output | 15 | Receive interrupt pulses per object |
| stat_irq | output | 1 | Status interrupt pulse |

## Verification
Two functions can act on the same pending flag in one cycle: a software write of 2'b01 to the pending field, and a qualifying hardware event. The bench sets up a receive object with its pending flag already set. It then drives that write and `rx_ok` for the object on the same clock edge. The readback must still show the field as 2'b10. The bench also makes `frame_ok` coincide with a reception while `stat_ie` is 1, and judges that the status pulse and the object pulse appear together in the same output cycle.

// File: rtl/mocr_pkg.sv
package mocr_pkg;
  localparam int FLAGS = 4;
  localparam int WORD_W = 2 * FLAGS;

  // Flag index k lives in bits [2k+1:2k]; the order is the word layout.
  localparam int F_PEND  = 0;
  localparam int F_RXIE  = 1;
  localparam int F_TXIE  = 2;
  localparam int F_VALID = 3;

  typedef enum logic [1:0] {
    PW_HOLD0 = 2'b00,
    PW_CLR   = 2'b01,
    PW_SET   = 2'b10,
    PW_HOLD1 = 2'b11
  } pair_wr_e;
endpackage

// File: rtl/mocr_pair_cell.sv
module mocr_pair_cell (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_stb,
  input  logic [1:0] wr_pair,
  input  logic       hw_set,
  output logic       flag
);
  import mocr_pkg::*;

  logic q;

  // Control flag: deliberately not reset.
  always_ff @(posedge clk) begin
    if (hw_set)
      q <= 1'b1;
    else if (wr_stb && pair_wr_e'(wr_pair) == PW_SET)
      q <= 1'b1;
    else if (wr_stb && pair_wr_e'(wr_pair) == PW_CLR)
      q <= 1'b0;
  end

  assign flag = q;

  p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && wr_pair == 2'b10) |=> flag);
  p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && wr_pair == 2'b01 && !hw_set) |=> !flag);
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!hw_set && (!wr_stb || wr_pair == 2'b00 || wr_pair == 2'b11)) |=> $stable(flag));
  p_hw_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    hw_set |=> flag);
endmodule

// File: rtl/mocr_object.sv
module mocr_object
  import mocr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              tx_ok,
  input  logic              rx_ok,
  input  logic              is_tx,
  input  logic              glb_ie,
  output logic [WORD_W-1:0] word,
  output logic              valid,
  output logic              tx_hit,
  output logic              rx_hit
);
  logic [FLAGS-1:0] fl;
  logic             hit_any;

  assign tx_hit  = tx_ok &  is_tx & fl[F_TXIE] & glb_ie;
  assign rx_hit  = rx_ok & ~is_tx & fl[F_RXIE] & glb_ie;
  assign hit_any = tx_hit | rx_hit;
  assign valid   = fl[F_VALID];

  for (genvar k = 0; k < FLAGS; k++) begin : g_pair
    logic hw;
    if (k == F_PEND) begin : g_hw
      assign hw = hit_any;
    end else begin : g_sw
      assign hw = 1'b0;
    end

    mocr_pair_cell u_cell (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_stb  (wr_stb),
      .wr_pair (wr_data[2*k+1 -: 2]),
      .hw_set  (hw),
      .flag    (fl[k])
    );

    assign word[2*k+1 -: 2] = {fl[k], ~fl[k]};
  end

  p_pend_after_tx_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_hit |=> word[1:0] == 2'b10);
  p_pend_after_rx_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_hit |=> word[1:0] == 2'b10);
  p_one_dir_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_hit && rx_hit));
endmodule

// File: rtl/mocr_irq_gen.sv
module mocr_irq_gen #(
  parameter int NOBJ = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NOBJ:1] tx_hit,
  input  logic [NOBJ:1] rx_hit,
  input  logic          frame_ok,
  input  logic          stat_ie,
  output logic [NOBJ:1] tx_irq,
  output logic [NOBJ:1] rx_irq,
  output logic          stat_irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_irq   <= '0;
      rx_irq   <= '0;
      stat_irq <= 1'b0;
    end else begin
      tx_irq   <= tx_hit;
      rx_irq   <= rx_hit;
      stat_irq <= frame_ok & stat_ie;
    end
  end

  p_stat_fire_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_ok && stat_ie) |=> stat_irq);
  p_stat_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_ok && stat_ie) |=> !stat_irq);
  p_rx_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_hit != '0) |=> (rx_irq != '0));
endmodule

// File: rtl/mocr_bank.sv
module mocr_bank
  import mocr_pkg::*;
#(
  parameter int NOBJ = 15,
  parameter int AW   = $clog2(NOBJ + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [AW-1:0]     rd_addr,
  output logic [WORD_W-1:0] rd_data,
  input  logic [NOBJ:1]     tx_ok,
  input  logic [NOBJ:1]     rx_ok,
  input  logic [NOBJ:1]     obj_is_tx,
  input  logic              frame_ok,
  input  logic              glb_ie,
  input  logic              stat_ie,
  output logic [NOBJ:1]     obj_valid,
  output logic [NOBJ:1]     tx_irq_vec,
  output logic [NOBJ:1]     rx_irq_vec,
  output logic              stat_irq
);
  logic [NOBJ:1][WORD_W-1:0] words;
  logic [NOBJ:1]             tx_hit, rx_hit;
  logic [WORD_W-1:0]         rd_sel;

  for (genvar i = 1; i <= NOBJ; i++) begin : g_obj
    mocr_object u_obj (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_stb  (wr_en && wr_addr == AW'(i)),
      .wr_data (wr_data),
      .tx_ok   (tx_ok[i]),
      .rx_ok   (rx_ok[i]),
      .is_tx   (obj_is_tx[i]),
      .glb_ie  (glb_ie),
      .word    (words[i]),
      .valid   (obj_valid[i]),
      .tx_hit  (tx_hit[i]),
      .rx_hit  (rx_hit[i])
    );
  end

  always_comb begin
    rd_sel = '0;
    for (int i = 1; i <= NOBJ; i++)
      if (rd_addr == AW'(i)) rd_sel = words[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      rd_data <= '0;
    else if (rd_en)
      rd_data <= rd_sel;
  end

  mocr_irq_gen #(.NOBJ(NOBJ)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_hit   (tx_hit),
    .rx_hit   (rx_hit),
    .frame_ok (frame_ok),
    .stat_ie  (stat_ie),
    .tx_irq   (tx_irq_vec),
    .rx_irq   (rx_irq_vec),
    .stat_irq (stat_irq)
  );

  p_rd_pairs_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr != '0 && int'(rd_addr) <= NOBJ) |=>
      ((rd_data[7] ^ rd_data[6]) && (rd_data[5] ^ rd_data[4]) &&
       (rd_data[3] ^ rd_data[2]) && (rd_data[1] ^ rd_data[0])));
  p_rd_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == '0) |=> rd_data == '0);
  p_glb_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_irq_vec != '0 || rx_irq_vec != '0) |-> $past(glb_ie));
endmodule

// File: tb/tb_mocr_bank.sv
module tb_mocr_bank;
  localparam int N = 15;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_en, rd_en, frame_ok, glb_ie, stat_ie;
  logic [3:0]    wr_addr, rd_addr;
  logic [7:0]    wr_data, rd_data;
  logic [N:1]    tx_ok, rx_ok, obj_is_tx, obj_valid, tx_irq_vec, rx_irq_vec;
  logic          stat_irq;
  int            nchk = 0, nfail = 0;
  bit            done = 0;

  always #5 clk = ~clk;

  mocr_bank dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .tx_ok(tx_ok), .rx_ok(rx_ok),
    .obj_is_tx(obj_is_tx), .frame_ok(frame_ok), .glb_ie(glb_ie), .stat_ie(stat_ie),
    .obj_valid(obj_valid), .tx_irq_vec(tx_irq_vec), .rx_irq_vec(rx_irq_vec),
    .stat_irq(stat_irq)
  );

  task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1; rd_addr = a;
    @(negedge clk); rd_en = 0; d = rd_data;
  endtask

  function automatic logic [N:1] bitv(int i);
    return N'(1) << (i - 1);
  endfunction

  task automatic t_reset;
    chk("R12 tx_irq after reset", 32'(tx_irq_vec), 0);
    chk("R12 rx_irq after reset", 32'(rx_irq_vec), 0);
    chk("R12 stat_irq after reset", 32'(stat_irq), 0);
    chk("R12 rd_data after reset", 32'(rd_data), 0);
  endtask

  task automatic t_init;
    logic [7:0] d;
    for (int i = 1; i <= N; i++) wr(4'(i), 8'h55);
    for (int i = 1; i <= N; i++) begin
      rd(4'(i), d);
      chk("R4 cleared word reads 55", 32'(d), 32'h55);
    end
    chk("R13 valid vector all clear", 32'(obj_valid), 0);
  endtask

  task automatic t_pairs;
    logic [7:0] d;
    wr(3, 8'hBF); rd(3, d); chk("R2 set valid only", 32'(d), 32'h95);
    chk("R13 obj_valid bit 3", 32'(obj_valid), 32'(bitv(3)));
    wr(3, 8'hEF); rd(3, d); chk("R3 set txie keeps valid", 32'(d), 32'hA5);
    wr(3, 8'h00); rd(3, d); chk("R3 00 holds all", 32'(d), 32'hA5);
    wr(3, 8'hFF); rd(3, d); chk("R3 11 holds all", 32'(d), 32'hA5);
    wr(3, 8'h7F); rd(3, d); chk("R2 clear valid", 32'(d), 32'h65);
    rd(4, d); chk("R3 neighbour untouched", 32'(d), 32'h55);
    chk("R13 obj_valid cleared", 32'(obj_valid), 0);
  endtask

  task automatic t_addr0;
    logic [7:0] d;
    wr(0, 8'hAA); rd(0, d); chk("R1 address 0 reads 0", 32'(d), 0);
    rd(1, d); chk("R1 addr 0 write dropped", 32'(d), 32'h55);
  endtask

  task automatic t_tx;
    logic [7:0] d;
    wr(2, 8'hEF);
    @(negedge clk); tx_ok[2] = 1;
    @(negedge clk); tx_ok = '0;
    chk("R5 tx pulse obj2", 32'(tx_irq_vec), 32'(bitv(2)));
    @(negedge clk); chk("R5 tx pulse one cycle", 32'(tx_irq_vec), 0);
    rd(2, d); chk("R5 pending set", 32'(d), 32'h66);
    wr(2, 8'hFD); rd(2, d); chk("R2 pending cleared", 32'(d), 32'h65);
  endtask

  task automatic t_rx;
    logic [7:0] d;
    wr(5, 8'hFB);
    @(negedge clk); rx_ok[5] = 1;
    @(negedge clk); rx_ok = '0;
    chk("R6 rx pulse obj5", 32'(rx_irq_vec), 32'(bitv(5)));
    chk("R6 no tx pulse", 32'(tx_irq_vec), 0);
    rd(5, d); chk("R6 pending set", 32'(d), 32'h5A);
    wr(5, 8'hFD); rd(5, d); chk("R6 pending cleared", 32'(d), 32'h59);
  endtask

  task automatic t_dir;
    logic [7:0] d;
    wr(2, 8'hFB); // obj2 (tx): also enable rx -> 01 10 10 01 = 0x69
    wr(5, 8'hEF); // obj5 (rx): also enable tx -> 01 10 10 01 = 0x69
    @(negedge clk); rx_ok[2] = 1; tx_ok[5] = 1;
    @(negedge clk); rx_ok = '0; tx_ok = '0;
    chk("R7 no rx pulse for tx obj", 32'(rx_irq_vec), 0);
    chk("R7 no tx pulse for rx obj", 32'(tx_irq_vec), 0);
    rd(2, d); chk("R7 obj2 pending clear", 32'(d), 32'h69);
    rd(5, d); chk("R7 obj5 pending clear", 32'(d), 32'h69);
  endtask

  task automatic t_glb;
    logic [7:0] d;
    @(negedge clk); glb_ie = 0; tx_ok[2] = 1; rx_ok[5] = 1;
    @(negedge clk); tx_ok = '0; rx_ok = '0;
    chk("R8 no tx pulse", 32'(tx_irq_vec), 0);
    chk("R8 no rx pulse", 32'(rx_irq_vec), 0);
    rd(2, d); chk("R8 pending untouched", 32'(d), 32'h69);
    glb_ie = 1;
  endtask

  task automatic t_stat;
    @(negedge clk); stat_ie = 1; frame_ok = 1;
    @(negedge clk); frame_ok = 0;
    chk("R9 stat pulse without object", 32'(stat_irq), 1);
    chk("R9 no object pulse", 32'(rx_irq_vec), 0);
    @(negedge clk); stat_ie = 0; frame_ok = 1;
    @(negedge clk); frame_ok = 0;
    chk("R9 no stat pulse when disabled", 32'(stat_irq), 0);
  endtask

  task automatic t_both;
    @(negedge clk); stat_ie = 1; frame_ok = 1; rx_ok[5] = 1;
    @(negedge clk); frame_ok = 0; rx_ok = '0;
    chk("R10 stat pulse", 32'(stat_irq), 1);
    chk("R10 rx pulse same cycle", 32'(rx_irq_vec), 32'(bitv(5)));
    stat_ie = 0;
  endtask

  task automatic t_race;
    logic [7:0] d;
    rd(5, d); chk("R11 pending set before race", 32'(d), 32'h6A);
    @(negedge clk); wr_en = 1; wr_addr = 5; wr_data = 8'hFD; rx_ok[5] = 1;
    @(negedge clk); wr_en = 0; rx_ok = '0;
    rd(5, d); chk("R11 hardware set wins", 32'(d), 32'h6A);
  endtask

  task automatic t_rst_keep;
    logic [7:0] d;
    @(negedge clk); rst_n = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
    t_reset();
    rd(2, d); chk("R12 word kept over reset", 32'(d), 32'h69);
    rd(3, d); chk("R12 word 3 kept over reset", 32'(d), 32'h65);
  endtask

  initial begin
    rst_n = 0; wr_en = 0; rd_en = 0; wr_addr = 0; rd_addr = 0; wr_data = 0;
    tx_ok = '0; rx_ok = '0; frame_ok = 0; glb_ie = 1; stat_ie = 0;
    obj_is_tx = bitv(2) | bitv(3);
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_init();
    t_pairs();
    t_addr0();
    t_tx();
    t_rx();
    t_dir();
    t_glb();
    t_stat();
    t_both();
    t_race();
    t_rst_keep();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule